// File: doc/BRIEF.md
# GPIO Configuration Port Behind an Unlock Key

This block is a legacy configuration space reached through two byte-wide I/O locations: an index port that names a register and a data port that reads or writes the register named. After reset the space is closed. A host opens it by writing a fixed four-byte key to the index port. Once it is open, the host can read two identification bytes and choose a logical device. When the GPIO logical device is chosen, the host can program a bank of eight pins through four registers: enable, direction, polarity invert and simple-or-alternate select.

No register holds the level an output pin drives. A driven pin takes a fixed per-pin pull level, or a slow blink when the alternate function is chosen, and XORs it with its polarity bit. Flipping the polarity bit therefore turns the pin on or off. A read-only status register returns the synchronised level present on each pad. The host closes the space with an exit command, and the programmed pin state is kept.

A simple strobe interface takes the place of the host bus. `io_data_sel_i` picks the data port (1) or the index port (0). `io_wr_i` and `io_rd_i` mark one access per cycle.

Top module: `sio_cfg_gpio`

## Requirements
- R1: After reset the space is closed, no pin is driven (`gpio_oe_o` = 0, `gpio_out_o` = 0), the index holds 0x07, the device select holds 0x00, enable = 0x0E, and direction, polarity and simple select are all 0x00.
- R2: Index-port writes of 0x87, 0x01, 0x55, 0x55 in that order open the space, and the last of these writes does not change the index.
- R3: A byte that does not match the expected key byte sends the key detector back to its first step. That byte is discarded, so it cannot start a new key, even when it equals 0x87.
- R4: While the space is closed, index-port and data-port reads return 0xFF, and data-port writes change no register.
- R5: Once the space is open, an index write selects a register and the data port accesses it. Register 0x20 reads 0x87 and register 0x21 reads 0x72. Both are read-only.
- R6: Register 0x07 selects the logical device. Registers 0x27 (enable), 0xBA (polarity), 0xC2 (simple select, 1 = simple I/O), 0xCA (direction, 1 = output) and 0xFC (pad status) respond only while device 7 is selected. At other times, and for any unmapped index, reads return 0x00 and writes are ignored.
- R7: Writing 0x02 to register 0x02 closes the space and sets the index back to 0x07. After that, reads return 0xFF, and all register values are kept for the next opening.
- R8: Pin i is driven (`gpio_oe_o[i]` = 1) exactly when its enable and direction bits are both 1. With simple select = 1, it drives `PULL_LEVEL[i]` XOR polarity[i]. An undriven pin outputs 0.
- R9: With simple select = 0, a driven pin outputs the blink signal XOR polarity[i]. The blink signal toggles once every `BLINK_HALF` clock cycles.
- R10: Register 0xFC returns the pad levels `gpio_in_i` through a two-stage synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr_i | input | 1 | Write strobe, one access per cycle |
| io_rd_i | input | 1 | Read strobe |
| io_data_sel_i | input | 1 | 1 = data port, 0 = index port |
| io_wdata_i | input | 8 | Write byte |
| io_rdata_o | output | 8 | Read byte, valid in the cycle of `io_rd_i`, 0x00 when no read is made |
| gpio_in_i | input | 8 | Sampled pad levels |
| gpio_out_o | output | 8 | Pin output level |
| gpio_oe_o | output | 8 | Pin output enable |

## Verification
The assertions assume that the host never asserts `io_wr_i` and `io_rd_i` in the same cycle. They also assume that strobes and write data are stable around the clock edge. The stimulus keeps to this by driving one access at a time, changing it on the falling edge. Pads come from a bench model that returns the driven level for output pins and a random level for the others, so the status register never sees a conflicting pad. Random register values only reach the GPIO bank after device 7 has been selected. Pins in blink mode are left out of the level comparison in the random phase, because their phase is free-running. They are checked separately by measuring the toggle interval.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam logic [7:0] KEY_B0 = 8'h87;
  localparam logic [7:0] KEY_B1 = 8'h01;
  localparam logic [7:0] KEY_B2 = 8'h55;
  localparam logic [7:0] KEY_B3 = 8'h55;

  localparam logic [7:0] IDX_EXIT   = 8'h02;
  localparam logic [7:0] IDX_DEVSEL = 8'h07;
  localparam logic [7:0] IDX_ID_HI  = 8'h20;
  localparam logic [7:0] IDX_ID_LO  = 8'h21;
  localparam logic [7:0] IDX_PIN_EN = 8'h27;
  localparam logic [7:0] IDX_INVERT = 8'hBA;
  localparam logic [7:0] IDX_SIMPLE = 8'hC2;
  localparam logic [7:0] IDX_DIR    = 8'hCA;
  localparam logic [7:0] IDX_STATUS = 8'hFC;

  localparam logic [7:0] GPIO_DEV   = 8'h07;
  localparam logic [7:0] EXIT_VALUE = 8'h02;

  typedef enum logic [2:0] {
    KS_IDLE, KS_GOT1, KS_GOT2, KS_GOT3, KS_OPEN
  } key_state_e;

  typedef struct packed {
    logic [7:0] en;
    logic [7:0] inv;
    logic [7:0] simple;
    logic [7:0] dir;
  } pin_cfg_t;
endpackage

// File: rtl/sio_key_detect.sv
module sio_key_detect
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  input  logic       exit_req,
  output logic       unlocked
);
  key_state_e st_q, st_d;

  function automatic logic [7:0] key_byte(key_state_e s);
    case (s)
      KS_IDLE: key_byte = KEY_B0;
      KS_GOT1: key_byte = KEY_B1;
      KS_GOT2: key_byte = KEY_B2;
      default: key_byte = KEY_B3;
    endcase
  endfunction

  always_comb begin
    st_d = st_q;
    if (st_q == KS_OPEN) begin
      if (exit_req) st_d = KS_IDLE;
    end else if (idx_wr) begin
      if (wdata == key_byte(st_q))
        st_d = (st_q == KS_GOT3) ? KS_OPEN : key_state_e'(st_q + 3'd1);
      else
        st_d = KS_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KS_IDLE;
    else        st_q <= st_d;
  end

  assign unlocked = (st_q == KS_OPEN);

  assert_key_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == KS_GOT3 && idx_wr && wdata == KEY_B3) |=> unlocked);

  assert_key_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != KS_OPEN && idx_wr && wdata != key_byte(st_q)) |=> (st_q == KS_IDLE));
endmodule

// File: rtl/sio_blink_div.sv
module sio_blink_div #(
  parameter int BLINK_HALF = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic blink
);
  localparam int CW = $clog2(BLINK_HALF) + 1;
  localparam logic [CW-1:0] LIM = CW'(BLINK_HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          blink_q, blink_d;
  logic          wrap;

  assign wrap = (cnt_q == LIM);

  always_comb begin
    cnt_d   = wrap ? '0 : cnt_q + 1'b1;
    blink_d = wrap ? ~blink_q : blink_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      blink_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      blink_q <= blink_d;
    end
  end

  assign blink = blink_q;

  assert_blink_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_pkg::*;
#(
  parameter logic [7:0] EN_RESET   = 8'h0E,
  parameter logic [7:0] CHIP_ID_HI = 8'h87,
  parameter logic [7:0] CHIP_ID_LO = 8'h72
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       unlocked,
  input  logic       idx_wr,
  input  logic       data_wr,
  input  logic [7:0] wdata,
  input  logic [7:0] pin_stat,
  output pin_cfg_t   cfg_o,
  output logic       exit_req,
  output logic [7:0] index_o,
  output logic [7:0] rd_val_o
);
  logic [7:0] index_q, index_d;
  logic [7:0] dev_q, dev_d;
  pin_cfg_t   cfg_q, cfg_d;
  logic       wr_ok, gpio_sel;

  assign wr_ok    = data_wr & unlocked;
  assign gpio_sel = (dev_q == GPIO_DEV);
  assign exit_req = wr_ok && (index_q == IDX_EXIT) && (wdata == EXIT_VALUE);

  always_comb begin
    index_d = index_q;
    if (exit_req)               index_d = IDX_DEVSEL;
    else if (idx_wr && unlocked) index_d = wdata;
  end

  always_comb begin
    dev_d = dev_q;
    cfg_d = cfg_q;
    if (wr_ok) begin
      if (index_q == IDX_DEVSEL) dev_d = wdata;
      if (gpio_sel) begin
        case (index_q)
          IDX_PIN_EN: cfg_d.en     = wdata;
          IDX_INVERT: cfg_d.inv    = wdata;
          IDX_SIMPLE: cfg_d.simple = wdata;
          IDX_DIR:    cfg_d.dir    = wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q      <= IDX_DEVSEL;
      dev_q        <= 8'h00;
      cfg_q.en     <= EN_RESET;
      cfg_q.inv    <= 8'h00;
      cfg_q.simple <= 8'h00;
      cfg_q.dir    <= 8'h00;
    end else begin
      index_q <= index_d;
      dev_q   <= dev_d;
      cfg_q   <= cfg_d;
    end
  end

  always_comb begin
    rd_val_o = 8'h00;
    case (index_q)
      IDX_DEVSEL: rd_val_o = dev_q;
      IDX_ID_HI:  rd_val_o = CHIP_ID_HI;
      IDX_ID_LO:  rd_val_o = CHIP_ID_LO;
      default: begin
        if (gpio_sel) begin
          case (index_q)
            IDX_PIN_EN: rd_val_o = cfg_q.en;
            IDX_INVERT: rd_val_o = cfg_q.inv;
            IDX_SIMPLE: rd_val_o = cfg_q.simple;
            IDX_DIR:    rd_val_o = cfg_q.dir;
            IDX_STATUS: rd_val_o = pin_stat;
            default:    rd_val_o = 8'h00;
          endcase
        end
      end
    endcase
  end

  assign cfg_o   = cfg_q;
  assign index_o = index_q;

  assert_locked_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && data_wr) |=> ($stable(cfg_q) && $stable(dev_q)));

  assert_bank_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_q != GPIO_DEV && data_wr) |=> $stable(cfg_q));
endmodule

// File: rtl/sio_gpio_pins.sv
module sio_gpio_pins
  import sio_pkg::*;
#(
  parameter int         NPINS      = 8,
  parameter logic [7:0] PULL_LEVEL = 8'hA5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pin_cfg_t         cfg,
  input  logic             blink,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] pin_stat
);
  logic [NPINS-1:0] sync1_q, sync2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  assign pin_stat = sync2_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic base;
    assign base       = cfg.simple[i] ? PULL_LEVEL[i] : blink;
    assign pin_oe[i]  = cfg.en[i] & cfg.dir[i];
    assign pin_out[i] = pin_oe[i] & (base ^ cfg.inv[i]);

    assert_simple_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(cfg) && cfg.simple[i]) |-> $stable(pin_out[i]));
  end
endmodule

// File: rtl/sio_cfg_gpio.sv
module sio_cfg_gpio
  import sio_pkg::*;
#(
  parameter int         BLINK_HALF = 25_000_000,
  parameter logic [7:0] PULL_LEVEL = 8'hA5,
  parameter logic [7:0] EN_RESET   = 8'h0E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_wr_i,
  input  logic       io_rd_i,
  input  logic       io_data_sel_i,
  input  logic [7:0] io_wdata_i,
  output logic [7:0] io_rdata_o,
  input  logic [7:0] gpio_in_i,
  output logic [7:0] gpio_out_o,
  output logic [7:0] gpio_oe_o
);
  localparam int NPINS = 8;

  logic       unlocked, exit_req, blink, idx_wr, data_wr;
  logic [7:0] index_q, rd_val, pin_stat;
  pin_cfg_t   cfg;

  assign idx_wr  = io_wr_i & ~io_data_sel_i;
  assign data_wr = io_wr_i &  io_data_sel_i;

  sio_key_detect u_key (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wdata(io_wdata_i),
    .exit_req(exit_req), .unlocked(unlocked)
  );

  sio_cfg_regs #(.EN_RESET(EN_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .unlocked(unlocked), .idx_wr(idx_wr),
    .data_wr(data_wr), .wdata(io_wdata_i), .pin_stat(pin_stat),
    .cfg_o(cfg), .exit_req(exit_req), .index_o(index_q), .rd_val_o(rd_val)
  );

  sio_blink_div #(.BLINK_HALF(BLINK_HALF)) u_blink (
    .clk(clk), .rst_n(rst_n), .blink(blink)
  );

  sio_gpio_pins #(.NPINS(NPINS), .PULL_LEVEL(PULL_LEVEL)) u_pins (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .blink(blink), .pad_in(gpio_in_i),
    .pin_out(gpio_out_o), .pin_oe(gpio_oe_o), .pin_stat(pin_stat)
  );

  always_comb begin
    if (!io_rd_i)           io_rdata_o = 8'h00;
    else if (!unlocked)     io_rdata_o = 8'hFF;
    else if (io_data_sel_i) io_rdata_o = rd_val;
    else                    io_rdata_o = index_q;
  end

  assert_chip_id_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && io_rd_i && io_data_sel_i && index_q == IDX_ID_HI) |-> (io_rdata_o == 8'h87));

  assert_exit_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && data_wr && index_q == IDX_EXIT && io_wdata_i == EXIT_VALUE) |=> !unlocked);

  assert_locked_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!unlocked) && !unlocked && io_rd_i) |-> (io_rdata_o == 8'hFF));
endmodule

// File: tb/sim_sio_cfg_gpio.sv
module sim_sio_cfg_gpio;
  localparam int         HALF = 8;
  localparam logic [7:0] PULL = 8'hA5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       io_wr = 1'b0, io_rd = 1'b0, io_sel = 1'b0;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata, gpio_out, gpio_oe, gpio_in;
  logic [7:0] ext = 8'h00;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  assign gpio_in = (gpio_oe & gpio_out) | (~gpio_oe & ext);

  sio_cfg_gpio #(.BLINK_HALF(HALF), .PULL_LEVEL(PULL), .EN_RESET(8'h0E)) u0 (
    .clk(clk), .rst_n(rst_n), .io_wr_i(io_wr), .io_rd_i(io_rd),
    .io_data_sel_i(io_sel), .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .gpio_in_i(gpio_in), .gpio_out_o(gpio_out), .gpio_oe_o(gpio_oe)
  );

  function automatic logic [7:0] f_oe(logic [7:0] en, logic [7:0] dir);
    return en & dir;
  endfunction

  function automatic logic [7:0] f_simple_out(logic [7:0] en, logic [7:0] dir,
                                               logic [7:0] inv, logic [7:0] simple);
    return (PULL ^ inv) & f_oe(en, dir) & simple;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    @(negedge clk);
    io_sel = sel; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(logic sel, output logic [7:0] d);
    @(negedge clk);
    io_sel = sel; io_rd = 1'b1;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic reg_wr(logic [7:0] idx, logic [7:0] d);
    wr(1'b0, idx); wr(1'b1, d);
  endtask

  task automatic reg_rd(logic [7:0] idx, output logic [7:0] d);
    wr(1'b0, idx); rd(1'b1, d);
  endtask

  task automatic unlock();
    wr(1'b0, 8'h87); wr(1'b0, 8'h01); wr(1'b0, 8'h55); wr(1'b0, 8'h55);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] en, dir, inv, simple;
    int cnt;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R4 locked reads
    check("R1 oe after reset", gpio_oe, 8'h00);
    check("R1 out after reset", gpio_out, 8'h00);
    rd(1'b1, v); check("R4 locked data read", v, 8'hFF);
    rd(1'b0, v); check("R4 locked index read", v, 8'hFF);
    wr(1'b1, 8'h05); // locked write aimed at device select (index 0x07)

    // R3 broken key: the mismatching 0x87 must not restart the key
    wr(1'b0, 8'h87); wr(1'b0, 8'h01); wr(1'b0, 8'h87);
    wr(1'b0, 8'h01); wr(1'b0, 8'h55); wr(1'b0, 8'h55);
    rd(1'b1, v); check("R3 still locked after bad key", v, 8'hFF);

    // R2 proper key
    unlock();
    rd(1'b0, v); check("R2 index kept at 07 after key", v, 8'h07);
    rd(1'b1, v); check("R4 locked write ignored, devsel", v, 8'h00);

    // R5 chip ID
    reg_rd(8'h20, v); check("R5 id hi", v, 8'h87);
    reg_rd(8'h21, v); check("R5 id lo", v, 8'h72);
    reg_wr(8'h20, 8'h00);
    reg_rd(8'h20, v); check("R5 id hi read-only", v, 8'h87);

    // R6 banking
    reg_wr(8'hCA, 8'hFF);
    reg_rd(8'h27, v); check("R6 enable hidden on device 0", v, 8'h00);
    reg_wr(8'h07, 8'h07);
    reg_rd(8'hCA, v); check("R6 dir write ignored on device 0", v, 8'h00);
    reg_rd(8'h27, v); check("R1 enable reset", v, 8'h0E);
    reg_rd(8'hBA, v); check("R1 invert reset", v, 8'h00);
    reg_rd(8'hC2, v); check("R1 simple reset", v, 8'h00);
    reg_rd(8'h30, v); check("R6 unmapped reads zero", v, 8'h00);
    check("R8 no drive with dir clear", gpio_oe, 8'h00);

    // R8 / R10 random programming
    for (int it = 0; it < 40; it++) begin
      en = 8'($urandom); dir = 8'($urandom);
      inv = 8'($urandom); simple = 8'($urandom);
      if (it == 0) begin en = 8'hFF; dir = 8'hFF; simple = 8'hFF; inv = 8'h00; end
      if (it == 1) begin en = 8'hFF; dir = 8'hFF; simple = 8'hFF; inv = 8'hFF; end
      ext = 8'($urandom);
      reg_wr(8'h27, en); reg_wr(8'hCA, dir);
      reg_wr(8'hBA, inv); reg_wr(8'hC2, simple);
      @(negedge clk);
      check("R8 output enable", gpio_oe, f_oe(en, dir));
      check("R8 simple level", gpio_out & simple, f_simple_out(en, dir, inv, simple));
      check("R8 undriven pins low", gpio_out & ~f_oe(en, dir), 8'h00);
      reg_rd(8'hFC, v);
      check("R10 pad status",
            v & ~(f_oe(en, dir) & ~simple),
            ((f_oe(en, dir) & f_simple_out(en, dir, inv, simple)) |
             (~f_oe(en, dir) & ext)) & ~(f_oe(en, dir) & ~simple));
    end

    // R9 blink interval on pin 1
    reg_wr(8'h27, 8'h02); reg_wr(8'hCA, 8'h02);
    reg_wr(8'hBA, 8'h00); reg_wr(8'hC2, 8'h00);
    v = gpio_out;
    cnt = 0;
    while (gpio_out == v && cnt < 100) begin @(negedge clk); cnt++; end
    v = gpio_out;
    cnt = 0;
    while (gpio_out == v && cnt < 100) begin @(negedge clk); cnt++; end
    check("R9 blink half period", 8'(cnt), 8'(HALF));
    check("R9 only pin 1 active", gpio_out & 8'hFD, 8'h00);

    // R7 exit keeps state
    reg_wr(8'hCA, 8'h3C);
    reg_wr(8'h02, 8'h02);
    rd(1'b1, v); check("R7 closed after exit", v, 8'hFF);
    wr(1'b1, 8'h00); // locked write aimed at device select
    unlock();
    rd(1'b0, v); check("R7 index back to 07", v, 8'h07);
    rd(1'b1, v); check("R4 devsel untouched while locked", v, 8'h07);
    reg_rd(8'hCA, v); check("R7 direction kept", v, 8'h3C);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule